// File: doc/BRIEF.md
# Battery Pack Protection and Power-Mode Controller

This block drives the charge-FET and discharge-FET gate levels of a battery pack and the enable of the regulator that powers the pack's microcontroller. A register bank supplies the requested FET states and the overcurrent-circuit control. The comparators supply two digitized fault flags: a slow overcurrent flag and a fast load-short flag. Each flag has its own delay counter. If either flag is held high for its full delay, a shared shutoff latch forces the discharge FET off. Each delay is a parameter counted in system clock cycles, and it stands in for an external timing capacitor.

Power-down is sequenced in steps. A request is accepted only when no charger is present. Once accepted, the discharge FET is forced off at once. The regulator stays on until the charger-sense line is sampled low, and only then does the block enter power-down with both FETs off. When a charger appears during power-down, the regulator comes back on in the next cycle. The register bank also receives a one-cycle reset pulse, and the controller returns to its normal running state.

Top module: `pack_guard_ctrl`

## Requirements
- R1: After reset the regulator is enabled, `bank_rst` is low, no shutoff is latched (`oc_status` low with `oc_en` high), and the FET drives follow the requests.
- R2: In the running state `cfet_drv` equals `cfet_req_off` and `dfet_drv` equals `dfet_req_off`; a drive level of 1 means the FET is off.
- R3: With `oc_en` high, `oc_flag` sampled high on `OC_DLY` consecutive rising edges latches a shutoff, and from that edge on `dfet_drv` is 1; a shorter run latches nothing.
- R4: With `oc_en` high, `short_flag` sampled high on `SHORT_DLY` consecutive rising edges latches the same shutoff; a shorter run latches nothing.
- R5: A fault flag that falls before its delay is complete clears its count, so the next run starts again from zero.
- R6: A latched shutoff holds until a one-cycle pulse on `soft_rst` or on `fet_cmd_stb`; at the edge that samples the pulse, the latch clears.
- R7: With `oc_en` low, no fault shutoff occurs and `oc_status` equals `oc_force`.
- R8: A `pd_req` sampled while `chg_present` is low forces `dfet_drv` to 1 from the next edge. The regulator then stays enabled until an edge samples `chg_present` low.
- R9: In power-down `reg_en` is 0 and both `cfet_drv` and `dfet_drv` are 1.
- R10: A `pd_req` sampled while `chg_present` is high has no effect.
- R11: `chg_present` sampled high in power-down sets `reg_en` at the next edge, together with a `bank_rst` pulse exactly one cycle long. The block is back in the running state one edge later.
- R12: With `oc_en` high, `oc_status` is 1 exactly while a shutoff is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfet_req_off | input | 1 | Requested charge-FET state from the bank, 1 = off |
| dfet_req_off | input | 1 | Requested discharge-FET state from the bank, 1 = off |
| fet_cmd_stb | input | 1 | Pulse: a new FET command was written |
| soft_rst | input | 1 | Pulse: reset command received |
| oc_en | input | 1 | Overcurrent circuit enabled |
| oc_force | input | 1 | Status level forced while the circuit is disabled |
| pd_req | input | 1 | Pulse: power-down requested |
| oc_flag | input | 1 | Digitized overcurrent comparator flag |
| short_flag | input | 1 | Digitized load-short comparator flag |
| chg_present | input | 1 | Charger-sense level, 1 = charger connected |
| cfet_drv | output | 1 | Charge-FET drive, 1 = off |
| dfet_drv | output | 1 | Discharge-FET drive, 1 = off |
| reg_en | output | 1 | Regulator enable |
| oc_status | output | 1 | Overcurrent status pin |
| bank_rst | output | 1 | One-cycle reset to the register bank on wake-up |

## Verification
The assertions assume that `pd_req`, `fet_cmd_stb` and `soft_rst` are single-cycle pulses and that the fault flags and `chg_present` are already synchronized to `clk`. The bench drives every input on the falling edge, so each value is held steady across exactly one rising edge, and it raises each strobe for a single cycle only. A discharge-drive rise with no fault flag in the cycle before is allowed only when the request itself changes or the block leaves the running state. The stimulus keeps `dfet_req_off` low during every fault sweep so that any such rise is attributed correctly.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {
    PG_RUN  = 2'd0,
    PG_WAIT = 2'd1,
    PG_DOWN = 2'd2,
    PG_WAKE = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pgc_fault_timer.sv
module pgc_fault_timer #(
  parameter int DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic flag,
  output logic expire
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;
  logic          live;

  assign live = arm & flag;

  always_comb begin
    if (!live)              cnt_nxt = '0;
    else if (cnt_q != LAST) cnt_nxt = cnt_q + 1'b1;
    else                    cnt_nxt = cnt_q;
  end

  assign cnt_en = (cnt_nxt != cnt_q);
  assign expire = live & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pgc_power_seq.sv
module pgc_power_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pd_req,
  input  logic                chg_present,
  output pgc_pkg::pg_state_e  state
);
  import pgc_pkg::*;

  pg_state_e st_q, st_nxt;
  logic      st_en;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      PG_RUN:  if (pd_req && !chg_present) st_nxt = PG_WAIT;
      PG_WAIT: if (!chg_present)           st_nxt = PG_DOWN;
      PG_DOWN: if (chg_present)            st_nxt = PG_WAKE;
      PG_WAKE:                             st_nxt = PG_RUN;
      default:                             st_nxt = PG_RUN;
    endcase
  end

  assign st_en = (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= PG_RUN;
    else if (st_en) st_q <= st_nxt;
  end

  assign state = st_q;
endmodule

// File: rtl/pack_guard_ctrl.sv
module pack_guard_ctrl #(
  parameter int OC_DLY    = 500000,
  parameter int SHORT_DLY = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfet_req_off,
  input  logic dfet_req_off,
  input  logic fet_cmd_stb,
  input  logic soft_rst,
  input  logic oc_en,
  input  logic oc_force,
  input  logic pd_req,
  input  logic oc_flag,
  input  logic short_flag,
  input  logic chg_present,
  output logic cfet_drv,
  output logic dfet_drv,
  output logic reg_en,
  output logic oc_status,
  output logic bank_rst
);
  import pgc_pkg::*;

  localparam int NPATH = 2;

  pg_state_e        pg_state;
  logic [NPATH-1:0] flag_vec, expire_vec;
  logic             running, trip_q, trip_nxt, trip_en, trip_clr;

  pgc_power_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .chg_present (chg_present),
    .state       (pg_state)
  );

  assign running  = (pg_state == PG_RUN);
  assign flag_vec = {short_flag, oc_flag};

  generate
    for (genvar g = 0; g < NPATH; g++) begin : g_path
      pgc_fault_timer #(.DLY(g == 0 ? OC_DLY : SHORT_DLY)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (oc_en & running),
        .flag   (flag_vec[g]),
        .expire (expire_vec[g])
      );
    end
  endgenerate

  assign trip_clr = soft_rst | fet_cmd_stb | ~oc_en | ~running;

  always_comb begin
    if (trip_clr) trip_nxt = 1'b0;
    else          trip_nxt = trip_q | (|expire_vec);
  end

  assign trip_en = (trip_nxt != trip_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trip_q <= 1'b0;
    else if (trip_en) trip_q <= trip_nxt;
  end

  assign cfet_drv  = cfet_req_off | (pg_state == PG_DOWN) | (pg_state == PG_WAKE);
  assign dfet_drv  = dfet_req_off | trip_q | ~running;
  assign reg_en    = (pg_state != PG_DOWN);
  assign oc_status = oc_en ? trip_q : oc_force;
  assign bank_rst  = (pg_state == PG_WAKE);
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               dfet_req_off,
  input logic               oc_en,
  input logic               oc_force,
  input logic               pd_req,
  input logic               oc_flag,
  input logic               short_flag,
  input logic               chg_present,
  input logic               cfet_drv,
  input logic               dfet_drv,
  input logic               reg_en,
  input logic               oc_status,
  input logic               bank_rst,
  input pgc_pkg::pg_state_e st
);
  import pgc_pkg::*;

  // R9: regulator off implies both FETs off
  p_down_fets_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (cfet_drv && dfet_drv));

  // R11: charger in power-down restarts regulator with bank reset
  p_wake_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en && chg_present) |=> (reg_en && bank_rst));

  // R11: bank reset is a single-cycle pulse
  p_bank_rst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rst |=> !bank_rst);

  // R10: charger present keeps the regulator on
  p_no_pd_on_charger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && chg_present) |=> reg_en);

  // R8: accepted request turns the discharge FET off next cycle, regulator still on
  p_pd_req_dfet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PG_RUN && pd_req && !chg_present) |=> (dfet_drv && reg_en));

  // R3: a fault shutoff needs a fault flag in the cycle before
  p_trip_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PG_RUN && $past(st == PG_RUN) && !dfet_req_off && !$past(dfet_req_off)
     && $rose(dfet_drv)) |-> $past(oc_flag || short_flag));

  // R7: disabled circuit reports the forced level
  p_forced_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_en && $past(!oc_en)) |-> (oc_status == oc_force));
endmodule

bind pack_guard_ctrl pgc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dfet_req_off (dfet_req_off),
  .oc_en        (oc_en),
  .oc_force     (oc_force),
  .pd_req       (pd_req),
  .oc_flag      (oc_flag),
  .short_flag   (short_flag),
  .chg_present  (chg_present),
  .cfet_drv     (cfet_drv),
  .dfet_drv     (dfet_drv),
  .reg_en       (reg_en),
  .oc_status    (oc_status),
  .bank_rst     (bank_rst),
  .st           (pg_state)
);

// File: tb/sim_pack_guard_ctrl.sv
module sim_pack_guard_ctrl;
  localparam int OCD = 12;
  localparam int SHD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cfet_req_off, dfet_req_off, fet_cmd_stb, soft_rst, oc_en, oc_force;
  logic pd_req, oc_flag, short_flag, chg_present;
  logic cfet_drv, dfet_drv, reg_en, oc_status, bank_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pack_guard_ctrl #(.OC_DLY(OCD), .SHORT_DLY(SHD)) u0 (
    .clk(clk), .rst_n(rst_n), .cfet_req_off(cfet_req_off), .dfet_req_off(dfet_req_off),
    .fet_cmd_stb(fet_cmd_stb), .soft_rst(soft_rst), .oc_en(oc_en), .oc_force(oc_force),
    .pd_req(pd_req), .oc_flag(oc_flag), .short_flag(short_flag), .chg_present(chg_present),
    .cfet_drv(cfet_drv), .dfet_drv(dfet_drv), .reg_en(reg_en), .oc_status(oc_status),
    .bank_rst(bank_rst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_latch(input bit use_soft);
    if (use_soft) soft_rst = 1'b1; else fet_cmd_stb = 1'b1;
    step(1);
    soft_rst = 1'b0;
    fet_cmd_stb = 1'b0;
  endtask

  // path 0 = overcurrent (R3), path 1 = load short (R4)
  task automatic fault_run(input int path, input int n);
    int  dly;
    bit  exp_trip;
    dly = (path == 0) ? OCD : SHD;
    exp_trip = (n >= dly);
    if (path == 0) oc_flag = 1'b1; else short_flag = 1'b1;
    step(n);
    oc_flag = 1'b0;
    short_flag = 1'b0;
    chk(path == 0 ? "R3" : "R4", $sformatf("dfet after %0d flag cycles", n), dfet_drv, exp_trip);
    chk("R12", "status follows latch", oc_status, exp_trip);
    step(3);
    chk(exp_trip ? "R6" : "R5", "level held after flag drop", dfet_drv, exp_trip);
    clear_latch(n[0]);
    chk("R6", "latch cleared by strobe", dfet_drv, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfet_req_off = 1'b0; dfet_req_off = 1'b0; fet_cmd_stb = 1'b0; soft_rst = 1'b0;
    oc_en = 1'b1; oc_force = 1'b0; pd_req = 1'b0; oc_flag = 1'b0; short_flag = 1'b0;
    chg_present = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1", "reg_en after reset", reg_en, 1);
    chk("R1", "bank_rst after reset", bank_rst, 0);
    chk("R1", "oc_status after reset", oc_status, 0);
    chk("R1", "dfet after reset", dfet_drv, 0);

    // R2: all request combinations
    for (int k = 0; k < 4; k++) begin
      cfet_req_off = k[0];
      dfet_req_off = k[1];
      step(1);
      chk("R2", "cfet follows request", cfet_drv, k[0]);
      chk("R2", "dfet follows request", dfet_drv, k[1]);
    end
    cfet_req_off = 1'b0;
    dfet_req_off = 1'b0;
    step(1);

    // R3 / R4 / R5 / R6 / R12: sweep flag run lengths
    for (int n = 1; n <= OCD + 2; n++) fault_run(0, n);
    for (int n = 1; n <= SHD + 2; n++) fault_run(1, n);

    // R5: interrupted runs never reach the delay
    oc_flag = 1'b1; step(OCD - 1); oc_flag = 1'b0; step(1);
    oc_flag = 1'b1; step(OCD - 1); oc_flag = 1'b0;
    chk("R5", "split overcurrent runs", dfet_drv, 0);
    short_flag = 1'b1; step(SHD - 1); short_flag = 1'b0; step(1);
    short_flag = 1'b1; step(SHD - 1); short_flag = 1'b0;
    chk("R5", "split short runs", dfet_drv, 0);

    // R6: latch holds for a long quiet time
    short_flag = 1'b1; step(SHD); short_flag = 1'b0;
    step(20);
    chk("R6", "latch held while quiet", dfet_drv, 1);
    clear_latch(1'b1);
    chk("R6", "latch cleared by soft reset", dfet_drv, 0);

    // R7: disabled circuit, both forced levels
    for (int f = 0; f < 2; f++) begin
      oc_en = 1'b0;
      oc_force = f[0];
      oc_flag = 1'b1;
      short_flag = 1'b1;
      step(OCD + 3);
      chk("R7", "no shutoff when disabled", dfet_drv, 0);
      chk("R7", "status forced", oc_status, f);
      oc_flag = 1'b0;
      short_flag = 1'b0;
      step(1);
    end
    oc_en = 1'b1;
    oc_force = 1'b0;
    step(1);

    // R10: request ignored with charger present
    chg_present = 1'b1;
    pd_req = 1'b1; step(1); pd_req = 1'b0;
    chk("R10", "dfet unchanged", dfet_drv, 0);
    step(3);
    chk("R10", "regulator still on", reg_en, 1);
    chk("R10", "dfet still on", dfet_drv, 0);

    // R8: accepted request, deferred by charger-sense high
    pd_req = 1'b1; chg_present = 1'b0; step(1); pd_req = 1'b0;
    chk("R8", "dfet forced off", dfet_drv, 1);
    chk("R8", "regulator on while waiting", reg_en, 1);
    chk("R8", "cfet unchanged while waiting", cfet_drv, 0);
    chg_present = 1'b1;
    step(2);
    chk("R8", "still waiting with sense high", reg_en, 1);
    chg_present = 1'b0;
    step(1);
    chk("R9", "regulator off", reg_en, 0);
    chk("R9", "cfet off", cfet_drv, 1);
    chk("R9", "dfet off", dfet_drv, 1);
    step(5);
    chk("R9", "regulator stays off", reg_en, 0);

    // R11: wake-up
    chg_present = 1'b1;
    step(1);
    chk("R11", "regulator back on", reg_en, 1);
    chk("R11", "bank reset pulse", bank_rst, 1);
    step(1);
    chk("R11", "bank reset ends", bank_rst, 0);
    chk("R11", "running again, dfet follows", dfet_drv, 0);
    chk("R11", "running again, cfet follows", cfet_drv, 0);
    step(2);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule